// File: doc/BRIEF.md
# Multi-bit Error Recovery Sequencer

This block is the control sequencer that takes over whenever the ECC checker on a second-level cache read flags a corrupted line. It accepts one error report at a time. The report gives the error class (correctable single-bit or uncorrectable multi-bit), the line index and the coherence state of the damaged line. The block then picks the cheapest recovery that still yields correct data. A single-bit error goes to the check-bit correction path with no further work. A multi-bit error on an invalid line needs no repair and is dropped. A multi-bit error on any live line first tries the local replication cache. If that cache holds no usable copy, a refetch goes out to peer caches or main memory.

Either way, the recovered line is written back into the L2 through one rewrite port. A one-cycle completion pulse then reports which path was taken. Until that pulse, the error-report interface is held not-ready, so a second report waits.

Top module: `mbe_recovery_seq`

## Requirements
- R1: After reset the block is idle: `err_ready` is 1, and `ecc_fix_valid`, `rc_req_valid`, `rf_req_valid`, `wr_valid` and `done_valid` are 0.
- R2: A report is taken when `err_valid` and `err_ready` are both 1. `err_ready` stays 0 from that point through the completion cycle and is 1 again in the cycle after it. Reports offered while busy are not taken, and the result carries the index of the report that was taken.
- R3: A report with `err_multi`=0 gives exactly one `ecc_fix_valid` pulse with the line index. It makes no lookup, refetch or rewrite, and it completes with outcome 0 (check-bit correction).
- R4: A report with `err_multi`=1 and L2 state code 0 (invalid) makes no lookup, refetch or rewrite, and it completes with outcome 3 (ignored).
- R5: A report with `err_multi`=1 and any L2 state code other than 0 raises `rc_req_valid` with the line index. It holds it until `rc_rsp_valid`, and it issues no refetch before the lookup has answered.
- R6: The replica is usable when `rc_rsp_hit`=1 and the returned state code is 1, 2, 3 or 4 (shared, exclusive, owned, modified). In that case its data is written to the L2 line with no refetch, and the block completes with outcome 1.
- R7: A lookup answer that is a miss, or that is a hit with state code 0 (invalid), 5 (stale, overwrite pending), 6 or 7, makes the block raise `rf_req_valid` with the line index. It holds the request until `rf_req_ready`.
- R8: After a refetch is accepted, the data on `rf_rsp_valid` is written to the L2 line and the block completes with outcome 2.
- R9: `wr_valid` stays high, with `wr_index` and `wr_data` stable, until `wr_ready`. `done_valid` rises in the cycle after the write is accepted.
- R10: `done_valid` is a single-cycle pulse carrying the index of the report and the outcome code (0 check-bit, 1 local copy, 2 remote copy, 3 ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error report offered |
| err_ready | output | 1 | Sequencer idle, report can be taken |
| err_multi | input | 1 | 1 = multi-bit error, 0 = single-bit |
| err_index | input | IDX_W | L2 line index of the error |
| err_l2_state | input | 3 | Coherence state code of the L2 line |
| ecc_fix_valid | output | 1 | Hand line to check-bit correction path |
| ecc_fix_index | output | IDX_W | Line index for check-bit correction |
| rc_req_valid | output | 1 | Replication cache lookup request |
| rc_req_index | output | IDX_W | Lookup line index |
| rc_rsp_valid | input | 1 | Lookup answer present |
| rc_rsp_hit | input | 1 | Lookup found a tag match |
| rc_rsp_state | input | 3 | State code of the replica |
| rc_rsp_data | input | LINE_W | Replica data |
| rf_req_valid | output | 1 | Refetch request to peers/memory |
| rf_req_index | output | IDX_W | Refetch line index |
| rf_req_ready | input | 1 | Refetch request accepted |
| rf_rsp_valid | input | 1 | Refetched data present |
| rf_rsp_data | input | LINE_W | Refetched line data |
| wr_valid | output | 1 | L2 line rewrite request |
| wr_index | output | IDX_W | Rewrite line index |
| wr_data | output | LINE_W | Rewrite data |
| wr_ready | input | 1 | L2 accepted the rewrite |
| done_valid | output | 1 | Completion pulse |
| done_outcome | output | 2 | Recovery path taken |
| done_index | output | IDX_W | Line index of the finished report |

## Verification
The hardest situation to reach is the one where a lookup hits but returns a replica in the stale or invalid state. That hit must still fall through to a refetch, and a lookup, a refetch and a stalled rewrite then all occur within one report. The stimulus draws the replica's hit flag and state code at random over all eight codes, together with random lookup, refetch and rewrite latencies. Directed cases pin the stale-hit and invalid-hit replicas. New reports are also offered at random while the block is busy, to show they are held off.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLASSIFY = 3'd1,
    ST_LOOKUP   = 3'd2,
    ST_REWRITE  = 3'd3,
    ST_RF_REQ   = 3'd4,
    ST_RF_WAIT  = 3'd5,
    ST_DONE     = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    OUT_ECC     = 2'd0,
    OUT_LOCAL   = 2'd1,
    OUT_REMOTE  = 2'd2,
    OUT_IGNORED = 2'd3
  } outcome_t;

  localparam logic [2:0] COH_INVALID = 3'd0;

  // a damaged L2 line only matters when it holds live data
  function automatic logic line_needs_fix(input logic [2:0] coh);
    return coh != COH_INVALID;
  endfunction

  // a replica is usable when it hit and its state code is enabled in the mask
  function automatic logic copy_usable(input logic hit, input logic [2:0] coh,
                                       input logic [7:0] ok_mask);
    return hit && ok_mask[coh];
  endfunction

endpackage

// File: rtl/mrs_decide.sv
module mrs_decide
  import mrs_pkg::*;
#(
  parameter logic [7:0] RC_OK_MASK = 8'b0001_1110
) (
  input  logic       cap_multi,
  input  logic [2:0] cap_l2_state,
  input  logic       rc_rsp_hit,
  input  logic [2:0] rc_rsp_state,
  output logic       route_ecc,
  output logic       route_ignore,
  output logic       copy_ok
);

  always_comb begin
    route_ecc    = !cap_multi;
    route_ignore = cap_multi && !line_needs_fix(cap_l2_state);
    copy_ok      = copy_usable(rc_rsp_hit, rc_rsp_state, RC_OK_MASK);
  end

endmodule

// File: rtl/mrs_line_reg.sv
module mrs_line_reg #(
  parameter int LINE_W = 64,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              err_multi,
  input  logic [IDX_W-1:0]  err_index,
  input  logic [2:0]        err_l2_state,
  input  logic              take_local,
  input  logic [LINE_W-1:0] rc_rsp_data,
  input  logic              take_remote,
  input  logic [LINE_W-1:0] rf_rsp_data,
  output logic              cap_multi,
  output logic [2:0]        cap_l2_state,
  output logic [IDX_W-1:0]  cap_index,
  output logic [LINE_W-1:0] cap_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_multi    <= 1'b0;
      cap_l2_state <= '0;
      cap_index    <= '0;
    end else if (accept) begin
      cap_multi    <= err_multi;
      cap_l2_state <= err_l2_state;
      cap_index    <= err_index;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_data <= '0;
    end else if (take_local) begin
      cap_data <= rc_rsp_data;
    end else if (take_remote) begin
      cap_data <= rf_rsp_data;
    end
  end

  AST_CAPTURE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_local && take_remote)); // R8

  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cap_index)); // R10

endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
  import mrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_valid,
  input  logic       route_ecc,
  input  logic       route_ignore,
  input  logic       rc_rsp_valid,
  input  logic       copy_ok,
  input  logic       rf_req_ready,
  input  logic       rf_rsp_valid,
  input  logic       wr_ready,
  output logic       err_ready,
  output logic       accept,
  output logic       ecc_fix_valid,
  output logic       rc_req_valid,
  output logic       rf_req_valid,
  output logic       wr_valid,
  output logic       take_local,
  output logic       take_remote,
  output logic       done_valid,
  output logic [1:0] done_outcome
);

  seq_state_t state_q, state_d;
  outcome_t   outc_q, outc_d;

  // named events used by the assertions
  logic lookup_answered;
  logic refetch_taken;
  logic rewrite_taken;

  always_comb begin
    err_ready       = (state_q == ST_IDLE);
    accept          = err_ready && err_valid;
    ecc_fix_valid   = (state_q == ST_CLASSIFY) && route_ecc;
    rc_req_valid    = (state_q == ST_LOOKUP);
    rf_req_valid    = (state_q == ST_RF_REQ);
    wr_valid        = (state_q == ST_REWRITE);
    done_valid      = (state_q == ST_DONE);
    done_outcome    = outc_q;
    lookup_answered = rc_req_valid && rc_rsp_valid;
    refetch_taken   = rf_req_valid && rf_req_ready;
    rewrite_taken   = wr_valid && wr_ready;
    take_local      = lookup_answered && copy_ok;
    take_remote     = (state_q == ST_RF_WAIT) && rf_rsp_valid;
  end

  always_comb begin
    state_d = state_q;
    outc_d  = outc_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_CLASSIFY;
      ST_CLASSIFY: begin
        if (route_ecc) begin
          outc_d  = OUT_ECC;
          state_d = ST_DONE;
        end else if (route_ignore) begin
          outc_d  = OUT_IGNORED;
          state_d = ST_DONE;
        end else begin
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lookup_answered) begin
          if (copy_ok) begin
            outc_d  = OUT_LOCAL;
            state_d = ST_REWRITE;
          end else begin
            state_d = ST_RF_REQ;
          end
        end
      end
      ST_RF_REQ:  if (refetch_taken) state_d = ST_RF_WAIT;
      ST_RF_WAIT: begin
        if (take_remote) begin
          outc_d  = OUT_REMOTE;
          state_d = ST_REWRITE;
        end
      end
      ST_REWRITE: if (rewrite_taken) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      outc_q  <= OUT_ECC;
    end else begin
      state_q <= state_d;
      outc_q  <= outc_d;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !err_ready); // R2

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> err_ready); // R2

  AST_ECC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fix_valid |-> !rc_req_valid && !rf_req_valid && !wr_valid); // R3

  AST_ECC_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fix_valid |=> done_valid && done_outcome == OUT_ECC); // R3

  AST_LOOKUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rc_req_valid && !rc_rsp_valid |=> rc_req_valid); // R5

  AST_REFETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid && !rf_req_ready |=> rf_req_valid); // R7

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_taken |=> done_valid); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10

endmodule

// File: rtl/mbe_recovery_seq.sv
module mbe_recovery_seq
  import mrs_pkg::*;
#(
  parameter int         LINE_W     = 64,
  parameter int         IDX_W      = 10,
  parameter logic [7:0] RC_OK_MASK = 8'b0001_1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic              err_multi,
  input  logic [IDX_W-1:0]  err_index,
  input  logic [2:0]        err_l2_state,
  output logic              ecc_fix_valid,
  output logic [IDX_W-1:0]  ecc_fix_index,
  output logic              rc_req_valid,
  output logic [IDX_W-1:0]  rc_req_index,
  input  logic              rc_rsp_valid,
  input  logic              rc_rsp_hit,
  input  logic [2:0]        rc_rsp_state,
  input  logic [LINE_W-1:0] rc_rsp_data,
  output logic              rf_req_valid,
  output logic [IDX_W-1:0]  rf_req_index,
  input  logic              rf_req_ready,
  input  logic              rf_rsp_valid,
  input  logic [LINE_W-1:0] rf_rsp_data,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_index,
  output logic [LINE_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              done_valid,
  output logic [1:0]        done_outcome,
  output logic [IDX_W-1:0]  done_index
);

  logic              accept;
  logic              take_local;
  logic              take_remote;
  logic              cap_multi;
  logic [2:0]        cap_l2_state;
  logic [IDX_W-1:0]  cap_index;
  logic [LINE_W-1:0] cap_data;
  logic              route_ecc;
  logic              route_ignore;
  logic              copy_ok;

  mrs_line_reg #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .err_multi    (err_multi),
    .err_index    (err_index),
    .err_l2_state (err_l2_state),
    .take_local   (take_local),
    .rc_rsp_data  (rc_rsp_data),
    .take_remote  (take_remote),
    .rf_rsp_data  (rf_rsp_data),
    .cap_multi    (cap_multi),
    .cap_l2_state (cap_l2_state),
    .cap_index    (cap_index),
    .cap_data     (cap_data)
  );

  mrs_decide #(.RC_OK_MASK(RC_OK_MASK)) u_decide (
    .cap_multi    (cap_multi),
    .cap_l2_state (cap_l2_state),
    .rc_rsp_hit   (rc_rsp_hit),
    .rc_rsp_state (rc_rsp_state),
    .route_ecc    (route_ecc),
    .route_ignore (route_ignore),
    .copy_ok      (copy_ok)
  );

  mrs_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_valid     (err_valid),
    .route_ecc     (route_ecc),
    .route_ignore  (route_ignore),
    .rc_rsp_valid  (rc_rsp_valid),
    .copy_ok       (copy_ok),
    .rf_req_ready  (rf_req_ready),
    .rf_rsp_valid  (rf_rsp_valid),
    .wr_ready      (wr_ready),
    .err_ready     (err_ready),
    .accept        (accept),
    .ecc_fix_valid (ecc_fix_valid),
    .rc_req_valid  (rc_req_valid),
    .rf_req_valid  (rf_req_valid),
    .wr_valid      (wr_valid),
    .take_local    (take_local),
    .take_remote   (take_remote),
    .done_valid    (done_valid),
    .done_outcome  (done_outcome)
  );

  assign ecc_fix_index = cap_index;
  assign rc_req_index  = cap_index;
  assign rf_req_index  = cap_index;
  assign wr_index      = cap_index;
  assign wr_data       = cap_data;
  assign done_index    = cap_index;

  AST_LOOKUP_BEFORE_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rc_req_valid |-> !rf_req_valid && !wr_valid); // R5

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_data) && $stable(wr_index)); // R9

  AST_LOCAL_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    take_local |=> wr_valid && !rf_req_valid); // R6

  AST_REMOTE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    take_remote |=> wr_valid && wr_data == $past(rf_rsp_data)); // R8

endmodule

// File: tb/test_mbe_recovery_seq.sv
module test_mbe_recovery_seq;

  localparam int LINE_W = 64;
  localparam int IDX_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              err_valid = 1'b0;
  logic              err_ready;
  logic              err_multi = 1'b0;
  logic [IDX_W-1:0]  err_index = '0;
  logic [2:0]        err_l2_state = '0;
  logic              ecc_fix_valid;
  logic [IDX_W-1:0]  ecc_fix_index;
  logic              rc_req_valid;
  logic [IDX_W-1:0]  rc_req_index;
  logic              rc_rsp_valid = 1'b0;
  logic              rc_rsp_hit = 1'b0;
  logic [2:0]        rc_rsp_state = '0;
  logic [LINE_W-1:0] rc_rsp_data = '0;
  logic              rf_req_valid;
  logic [IDX_W-1:0]  rf_req_index;
  logic              rf_req_ready = 1'b0;
  logic              rf_rsp_valid = 1'b0;
  logic [LINE_W-1:0] rf_rsp_data = '0;
  logic              wr_valid;
  logic [IDX_W-1:0]  wr_index;
  logic [LINE_W-1:0] wr_data;
  logic              wr_ready = 1'b0;
  logic              done_valid;
  logic [1:0]        done_outcome;
  logic [IDX_W-1:0]  done_index;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  mbe_recovery_seq #(.LINE_W(LINE_W), .IDX_W(IDX_W)) i_mbe_recovery_seq (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_ready(err_ready), .err_multi(err_multi),
    .err_index(err_index), .err_l2_state(err_l2_state),
    .ecc_fix_valid(ecc_fix_valid), .ecc_fix_index(ecc_fix_index),
    .rc_req_valid(rc_req_valid), .rc_req_index(rc_req_index),
    .rc_rsp_valid(rc_rsp_valid), .rc_rsp_hit(rc_rsp_hit),
    .rc_rsp_state(rc_rsp_state), .rc_rsp_data(rc_rsp_data),
    .rf_req_valid(rf_req_valid), .rf_req_index(rf_req_index),
    .rf_req_ready(rf_req_ready), .rf_rsp_valid(rf_rsp_valid),
    .rf_rsp_data(rf_rsp_data),
    .wr_valid(wr_valid), .wr_index(wr_index), .wr_data(wr_data),
    .wr_ready(wr_ready),
    .done_valid(done_valid), .done_outcome(done_outcome), .done_index(done_index)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // expected outcome from R3, R4, R6, R7, R8
  function automatic int exp_outcome(bit multi, bit [2:0] l2st, bit hit, bit [2:0] rst);
    if (!multi) return 0;
    if (l2st == 3'd0) return 3;
    if (hit && rst >= 3'd1 && rst <= 3'd4) return 1;
    return 2;
  endfunction

  task automatic run_case(input bit multi, input bit [2:0] l2st, input bit [IDX_W-1:0] idx,
                          input bit hit, input bit [2:0] rst,
                          input bit [LINE_W-1:0] rdata, input bit [LINE_W-1:0] fdata,
                          input int rc_lat, input int rq_lat, input int rs_lat,
                          input int wr_lat, input bit poke_busy);
    int  exp_o = exp_outcome(multi, l2st, hit, rst);
    int  n_ecc = 0;
    bit  saw_rc = 0, saw_rf = 0, saw_wr = 0, saw_done = 0;
    bit  rf_before_rc = 0, idx_ok = 1, busy_ok = 1, stab_ok = 1, done_time_ok = 1;
    bit  rc_sent = 0, rf_acc = 0, rf_sent = 0, wr_acc_prev = 0;
    int  rc_cnt = 0, rq_cnt = 0, rs_cnt = 0, wr_cnt = 0;
    logic [LINE_W-1:0] first_wr = '0;
    logic [LINE_W-1:0] exp_data = (exp_o == 1) ? rdata : fdata;

    @(negedge clk);
    check(err_ready === 1'b1, "R2", "ready before report", err_ready, 1);
    err_valid = 1; err_multi = multi; err_l2_state = l2st; err_index = idx;
    for (int k = 0; k < 200 && !saw_done; k++) begin
      @(negedge clk);
      rc_rsp_valid = 0; rf_req_ready = 0; rf_rsp_valid = 0; wr_ready = 0;
      if (poke_busy && ($urandom_range(0, 1) == 1)) begin
        err_valid = 1; err_multi = ~multi; err_index = ~idx; err_l2_state = 3'd4;
      end else begin
        err_valid = 0;
      end
      if (err_ready !== 1'b0) busy_ok = 0;
      if (ecc_fix_valid) begin n_ecc++; if (ecc_fix_index !== idx) idx_ok = 0; end
      if (done_valid) begin
        saw_done = 1;
        err_valid = 0;
        if (saw_wr && !wr_acc_prev) done_time_ok = 0;
        check(done_outcome == exp_o[1:0], "R10", "outcome", done_outcome, exp_o);
        check(done_index === idx, "R10", "done index", done_index, idx);
      end else if (wr_acc_prev) begin
        done_time_ok = 0;
      end
      wr_acc_prev = 0;
      if (rc_req_valid) begin
        saw_rc = 1;
        if (rc_req_index !== idx) idx_ok = 0;
        if (!rc_sent) begin
          if (rc_cnt == rc_lat) begin
            rc_rsp_valid = 1; rc_rsp_hit = hit; rc_rsp_state = rst; rc_rsp_data = rdata;
            rc_sent = 1;
          end else rc_cnt++;
        end
      end
      if (rf_req_valid) begin
        if (!saw_rc) rf_before_rc = 1;
        saw_rf = 1;
        if (rf_req_index !== idx) idx_ok = 0;
        if (rq_cnt == rq_lat) begin rf_req_ready = 1; rf_acc = 1; end else rq_cnt++;
      end else if (rf_acc && !rf_sent) begin
        if (rs_cnt == rs_lat) begin
          rf_rsp_valid = 1; rf_rsp_data = fdata; rf_sent = 1;
        end else rs_cnt++;
      end
      if (wr_valid) begin
        if (!saw_wr) first_wr = wr_data;
        else if (wr_data !== first_wr) stab_ok = 0;
        saw_wr = 1;
        if (wr_index !== idx) idx_ok = 0;
        if (wr_cnt == wr_lat) begin wr_ready = 1; wr_acc_prev = 1; end else wr_cnt++;
      end
    end
    err_valid = 0;
    check(saw_done, "R10", "completion seen", saw_done, 1);
    check(busy_ok, "R2", "ready low while busy", busy_ok, 1);
    check(idx_ok, "R2", "index on all ports", idx_ok, 1);
    check(n_ecc == (exp_o == 0 ? 1 : 0), "R3", "check-bit pulses", n_ecc, exp_o == 0);
    check(saw_rc == (exp_o == 1 || exp_o == 2), "R5", "lookup issued", saw_rc,
          exp_o == 1 || exp_o == 2);
    check(!rf_before_rc, "R5", "refetch before lookup", rf_before_rc, 0);
    if (exp_o == 3) check(!saw_wr && !saw_rc, "R4", "ignored line touched", saw_wr, 0);
    check(saw_rf == (exp_o == 2), "R7", "refetch issued", saw_rf, exp_o == 2);
    check(saw_wr == (exp_o == 1 || exp_o == 2), "R6", "rewrite issued", saw_wr,
          exp_o == 1 || exp_o == 2);
    if (saw_wr) begin
      check(first_wr === exp_data, (exp_o == 1) ? "R6" : "R8", "rewrite data",
            first_wr, exp_data);
      check(stab_ok, "R9", "rewrite stable", stab_ok, 1);
    end
    check(done_time_ok, "R9", "done after write accept", done_time_ok, 1);
    @(negedge clk);
    check(done_valid === 1'b0, "R10", "done single cycle", done_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    check(err_ready === 1'b1 && !ecc_fix_valid && !rc_req_valid && !rf_req_valid
          && !wr_valid && !done_valid, "R1", "reset state",
          {err_ready, ecc_fix_valid, rc_req_valid, rf_req_valid, wr_valid, done_valid},
          6'b100000);
    rst_n = 1;
    @(negedge clk);
    check(err_ready === 1'b1 && !done_valid, "R1", "idle after reset", err_ready, 1);

    // directed corners
    run_case(0, 3'd4, 10'h011, 1, 3'd4, 64'hA, 64'hB, 0, 0, 0, 0, 0); // R3
    run_case(1, 3'd0, 10'h022, 1, 3'd4, 64'hA, 64'hB, 0, 0, 0, 0, 1); // R4
    run_case(1, 3'd1, 10'h033, 1, 3'd1, 64'h1111, 64'h2222, 2, 0, 0, 3, 0); // R6
    run_case(1, 3'd4, 10'h044, 1, 3'd5, 64'h3333, 64'h4444, 0, 2, 3, 1, 0); // R7 stale hit
    run_case(1, 3'd2, 10'h055, 1, 3'd0, 64'h5555, 64'h6666, 1, 0, 0, 0, 1); // R7 invalid hit
    run_case(1, 3'd3, 10'h066, 0, 3'd4, 64'h7777, 64'h8888, 3, 3, 3, 3, 1); // R8 miss

    for (int t = 0; t < 300; t++) begin
      bit [2:0] l2 = 3'($urandom_range(0, 7));
      run_case(1'($urandom_range(0, 3) != 0), l2, 10'($urandom),
               1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               {$urandom, $urandom}, {$urandom, $urandom},
               $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end

endmodule